// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine with Circular Sample Window

This block computes one output of a finite-impulse-response filter, the sum over `i` of `c[i] * x[j-i]`. Here `x[j]` is the newest sample accepted and `c[i]` are the tap coefficients. The coefficients and the samples are held in two separate register banks, so one coefficient and one sample are read in the same cycle. A dedicated address unit walks the coefficient bank upward from index 0. In parallel, it walks the sample bank downward from the newest sample. Both pointers are modulo the tap count, so the sample bank works as a ring that slides by one entry for each accepted sample.

A computation starts with the `start` pin. The first operand pair is preloaded in the start cycle. After that, one product is accumulated on every cycle, with no per-tap control cycles. Each product is shifted right arithmetically to restore the binary point. It is then added into the accumulator, either with wrap-around or with saturation, as chosen by `sat_mode` when the computation starts. The result leaves on a valid/ready output. It is held until it is accepted, and a new computation cannot start while a result is pending.

Samples enter on a valid/ready input. A sample transfers on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low for the whole computation, which applies back-pressure so that the window cannot move under the running loop. Coefficients are loaded through a plain write port.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `y_valid`, `done` and `y_data` are 0 and `s_ready` is 1.
- R2: When the block is idle, a sample offered on `s_valid` is accepted and written to the ring at the head position. The head then advances modulo TAPS.
- R3: A write on `coef_we` stores `coef_data` as coefficient `c[coef_addr]`. Coefficient index 0 multiplies the newest sample.
- R4: The result is the sum over `i = 0..TAPS-1` of `(c[i] * x[j-i]) >>> SHIFT`. Each product is signed, and the shift is arithmetic and is applied per product.
- R5: `done` and `y_valid` rise exactly TAPS clock edges after the edge that accepts `start`.
- R6: With `sat_mode` = 0 at start, the accumulation wraps modulo 2^ACC_W at every step.
- R7: With `sat_mode` = 1 at start, any step that overflows is clamped to 2^(ACC_W-1)-1, and any step that underflows is clamped to -2^(ACC_W-1). `sat_mode` is sampled only at the start edge.
- R8: `done` is a one-cycle pulse. `y_valid` and `y_data` hold steady until `y_ready` is seen high, and `y_valid` falls after that edge.
- R9: `start` is ignored while a computation runs or while a result is pending. It produces no further `done`, and `y_data` stays unchanged.
- R10: `s_ready` is 0 during a computation. A sample offered then is not written, and later results show an unchanged ring.
- R11: The ring holds the TAPS newest samples. After more than TAPS writes, the oldest samples are dropped, and `x[j-i]` follows the order of arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle with no pending result) |
| sat_mode | input | 1 | 0 = wrap-around accumulation, 1 = saturating; sampled at start |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(TAPS) | Coefficient index |
| coef_data | input | COEF_W | Signed coefficient value |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready (high when idle) |
| s_data | input | DATA_W | Signed sample value |
| y_valid | output | 1 | Result valid |
| y_ready | input | 1 | Result accepted |
| y_data | output | ACC_W | Signed result |
| done | output | 1 | One-cycle pulse when a result is produced |

## Verification
Some behaviours are checked by assertions on every cycle. These are the exact TAPS-edge latency from an accepted start to `done`, the single-cycle width of `done`, and the hold of `y_data` under back-pressure. They also cover `s_ready` staying low for the whole run. The numeric behaviours can only be shown by the bench scenarios: the arithmetic result, its wrap or clamp, and the ordering of the sliding window. The bench sweeps a small configuration with varying coefficient sets, varying sample counts between runs and both accumulation modes. The same scenarios show that starts and samples offered while busy leave no trace.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {
    ACC_WRAP = 1'b0,
    ACC_SAT  = 1'b1
  } acc_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } loop_state_e;
endpackage

// File: rtl/fir_bank.sv
// Single write port, single asynchronous read port register bank.
module fir_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fir_agu.sv
// Address unit: ring head pointer, post-increment coefficient pointer,
// post-decrement sample pointer, all modulo TAPS.
module fir_agu #(
  parameter int TAPS = 8,
  localparam int AW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          load,
  input  logic          step,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] c_addr,
  output logic [AW-1:0] s_addr
);
  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

  function automatic logic [AW-1:0] mod_inc(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] mod_dec(input logic [AW-1:0] a);
    return (a == '0) ? LAST : a - AW'(1);
  endfunction

  logic [AW-1:0] head_q, cptr_q, sptr_q;
  logic [AW-1:0] newest, second;

  assign newest  = mod_dec(head_q);
  assign second  = mod_dec(newest);
  assign wr_addr = head_q;
  assign c_addr  = load ? '0 : cptr_q;
  assign s_addr  = load ? newest : sptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cptr_q <= '0;
      sptr_q <= '0;
    end else begin
      if (wr_en) head_q <= mod_inc(head_q);
      if (load) begin
        cptr_q <= mod_inc('0);
        sptr_q <= second;
      end else if (step) begin
        cptr_q <= mod_inc(cptr_q);
        sptr_q <= mod_dec(sptr_q);
      end
    end
  end
endmodule

// File: rtl/fir_mac.sv
// Operand registers, multiplier, binary-point shift and accumulator.
module fir_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 12,
  parameter int SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              sat,
  input  logic [DATA_W-1:0] x_in,
  input  logic [COEF_W-1:0] c_in,
  output logic [ACC_W-1:0]  acc_nx
);
  localparam int PW = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [DATA_W-1:0] mx_q;
  logic signed [COEF_W-1:0] my_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [PW-1:0]     prod, prod_sh;
  logic signed [ACC_W-1:0]  pext;
  logic signed [ACC_W:0]    sum;
  logic                     ovf;

  assign prod    = mx_q * my_q;
  assign prod_sh = prod >>> SHIFT;
  assign pext    = ACC_W'(prod_sh);
  assign sum     = {acc_q[ACC_W-1], acc_q} + {pext[ACC_W-1], pext};
  assign ovf     = sum[ACC_W] ^ sum[ACC_W-1];

  always_comb begin
    if (sat && ovf) acc_nx = sum[ACC_W] ? MINV : MAXV;
    else            acc_nx = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mx_q  <= '0;
      my_q  <= '0;
      acc_q <= '0;
    end else if (clr) begin
      mx_q  <= x_in;
      my_q  <= c_in;
      acc_q <= '0;
    end else if (en) begin
      mx_q  <= x_in;
      my_q  <= c_in;
      acc_q <= acc_nx;
    end
  end
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 12,
  parameter int SHIFT  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    sat_mode,
  input  logic                    coef_we,
  input  logic [$clog2(TAPS)-1:0] coef_addr,
  input  logic [COEF_W-1:0]       coef_data,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [DATA_W-1:0]       s_data,
  output logic                    y_valid,
  input  logic                    y_ready,
  output logic [ACC_W-1:0]        y_data,
  output logic                    done
);
  localparam int AW = $clog2(TAPS);
  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

  loop_state_e   st_q;
  acc_mode_e     mode_q;
  logic [AW-1:0] cnt_q;
  logic          accept, step, last, wr_en;
  logic [AW-1:0] wr_addr, c_addr, s_addr;
  logic [DATA_W-1:0] x_rd;
  logic [COEF_W-1:0] c_rd;
  logic [ACC_W-1:0]  acc_nx;

  assign s_ready = (st_q == ST_IDLE);
  assign wr_en   = s_valid && s_ready;
  assign accept  = start && (st_q == ST_IDLE) && !y_valid;
  assign step    = (st_q == ST_RUN);
  assign last    = step && (cnt_q == LAST);

  fir_agu #(.TAPS(TAPS)) u_agu (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .load(accept), .step(step),
    .wr_addr(wr_addr), .c_addr(c_addr), .s_addr(s_addr)
  );

  fir_bank #(.W(DATA_W), .DEPTH(TAPS)) u_xbank (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(s_data),
    .raddr(s_addr), .rdata(x_rd)
  );

  fir_bank #(.W(COEF_W), .DEPTH(TAPS)) u_cbank (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
    .raddr(c_addr), .rdata(c_rd)
  );

  fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(step),
    .sat(mode_q == ACC_SAT), .x_in(x_rd), .c_in(c_rd), .acc_nx(acc_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= ACC_WRAP;
      cnt_q   <= '0;
      y_valid <= 1'b0;
      y_data  <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        st_q   <= ST_RUN;
        cnt_q  <= '0;
        mode_q <= acc_mode_e'(sat_mode);
      end else if (step) begin
        cnt_q <= cnt_q + AW'(1);
        if (last) st_q <= ST_IDLE;
      end
      if (last) begin
        y_valid <= 1'b1;
        y_data  <= acc_nx;
      end else if (y_valid && y_ready) begin
        y_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
  parameter int TAPS  = 8,
  parameter int ACC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             s_ready,
  input logic             y_valid,
  input logic             y_ready,
  input logic [ACC_W-1:0] y_data,
  input logic             done
);
  logic inrun;
  int   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inrun <= 1'b0;
      cnt   <= 0;
    end else if (start && s_ready && !y_valid) begin
      inrun <= 1'b1;
      cnt   <= 0;
    end else if (inrun) begin
      cnt <= cnt + 1;
      if (done) inrun <= 1'b0;
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inrun && cnt == TAPS));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> y_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data)));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inrun && !done) |-> !s_ready);
endmodule

bind fir_mac_engine fir_mac_engine_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .s_ready(s_ready),
  .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .done(done)
);

// File: tb/fir_mac_engine_tb.sv
module fir_mac_engine_tb;
  localparam int TAPS = 8, DW = 8, CW = 8, AW_ACC = 12, SH = 4;
  localparam int AMAX = 2047, AMIN = -2048;

  logic clk = 0, rst_n = 0, start = 0, sat_mode = 0, coef_we = 0;
  logic [2:0] coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic s_valid = 0, s_ready, y_valid, y_ready = 0, done;
  logic [DW-1:0] s_data = '0;
  logic [AW_ACC-1:0] y_data;

  int vectors = 0, miss = 0, wd = 0;
  int hist[$];
  int coefs[TAPS];
  int unsigned seed = 32'h1234_5678;

  fir_mac_engine #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .ACC_W(AW_ACC), .SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sat_mode(sat_mode),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .done(done)
  );

  always #4 clk = ~clk;

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      vectors++; miss++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[23:16]));
  endfunction

  task automatic set_coef(input int i, input int v);
    @(negedge clk);
    coef_we = 1; coef_addr = 3'(i); coef_data = CW'(v);
    @(negedge clk);
    coef_we = 0;
    coefs[i] = v;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    chk(s_ready == 1'b1, "R2 s_ready idle", int'(s_ready), 1);
    s_valid = 1; s_data = DW'(v);
    @(negedge clk);
    s_valid = 0;
    hist.push_back(v);
  endtask

  function automatic int model(input bit sat);
    int acc = 0;
    for (int i = 0; i < TAPS; i++) begin
      int p = (hist[hist.size()-1-i] * coefs[i]) >>> SH;
      int s = acc + p;
      if (sat) begin
        if (s > AMAX) s = AMAX;
        if (s < AMIN) s = AMIN;
      end else begin
        s = s & 12'hFFF;
        if (s > AMAX) s -= 4096;
      end
      acc = s;
    end
    return acc;
  endfunction

  // Runs one computation; returns the observed result.
  task automatic run_one(input bit sat, input bit poke, input string req, output int got);
    int exp = model(sat);
    int cyc = 0;
    @(negedge clk);
    start = 1; sat_mode = sat;
    @(negedge clk);
    start = 0; sat_mode = ~sat;          // R7: mode only sampled at start
    while (!done && cyc < 4 * TAPS) begin
      if (poke && cyc == 2) begin
        s_valid = 1; s_data = 8'd99; start = 1;
        chk(s_ready == 1'b0, "R10 s_ready busy", int'(s_ready), 0);
      end
      @(negedge clk);
      cyc++;
      s_valid = 0; start = 0;
    end
    chk(cyc == TAPS, "R5 latency", cyc, TAPS);
    chk(y_valid == 1'b1, "R8 y_valid at done", int'(y_valid), 1);
    got = int'($signed(y_data));
    chk(got == exp, req, got, exp);
    for (int k = 0; k < 3; k++) begin
      start = 1;                          // R9: ignored while result pending
      @(negedge clk);
      chk(!done, "R9 no extra done", int'(done), 0);
      chk(y_valid && int'($signed(y_data)) == exp, "R8 hold", int'($signed(y_data)), exp);
    end
    start = 0; y_ready = 1;
    @(negedge clk);
    y_ready = 0;
    chk(y_valid == 1'b0, "R8 consumed", int'(y_valid), 0);
  endtask

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!y_valid && !done && y_data == '0 && s_ready, "R1 reset", int'(y_valid), 0);

    // R3 / R11: impulse coefficient at each tap picks out x[j-k] in arrival order
    for (int i = 0; i < TAPS; i++) set_coef(i, 0);
    for (int i = 0; i < TAPS + 3; i++) push(rnd8());
    for (int k = 0; k < TAPS; k++) begin
      if (k > 0) set_coef(k - 1, 0);
      set_coef(k, 16);
      run_one(0, 0, "R3 R11 impulse tap", got);
      chk(got == hist[hist.size()-1-k], "R11 window order", got, hist[hist.size()-1-k]);
    end

    // R4 / R6 / R7 / R2: sweep coefficient sets, sample counts and modes
    for (int t = 0; t < 72; t++) begin
      if (t % 6 == 0) for (int i = 0; i < TAPS; i++) set_coef(i, rnd8());
      for (int n = 0; n < (t % 9) + 1; n++) push(rnd8());
      run_one(t[0], (t % 5) == 1, t[0] ? "R4 R7 sat sweep" : "R4 R6 wrap sweep", got);
    end

    // R6 / R7 directed overflow: all products +1024
    for (int i = 0; i < TAPS; i++) set_coef(i, -128);
    for (int i = 0; i < TAPS; i++) push(-128);
    run_one(0, 0, "R6 wrap overflow", got);
    chk(got == 0, "R6 wrap to zero", got, 0);
    run_one(1, 0, "R7 sat overflow", got);
    chk(got == AMAX, "R7 clamp max", got, AMAX);

    // R7 directed underflow: all products -1016
    for (int i = 0; i < TAPS; i++) push(127);
    run_one(1, 1, "R7 sat underflow", got);
    chk(got == AMIN, "R7 clamp min", got, AMIN);
    run_one(0, 0, "R6 wrap underflow", got);

    report();
    $finish;
  end
endmodule